// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block decides who drives a local processor bus: the CPU side or an external bus master. The external master raises an active-high hold request. The controller grants it by raising an acknowledge. In that same cycle it releases the address/data, control, status and lock outputs to high impedance, which it does by dropping their output enables. The grant is given only between bus cycles and never while a locked instruction holds the bus.

On the CPU side, a bus-cycle request and a three-bit cycle type come in. The controller starts the cycle, presents the type on the status code and keeps it there until the cycle-done strobe arrives. It also drives an active-low lock output for locked instructions and refuses to start instruction fetches while that output is asserted. An enhanced mode lets the controller ask for the bus back when a memory refresh becomes pending during a hold: it drops the acknowledge while the request is still high, then waits for the master to withdraw.

Top module: `bus_hold_ctl`

## Requirements
- R1: While reset is asserted, hlda is 0, bus_oe and ctl_oe are 1, status is 111 (passive), lock_n is 1, and stat_oe and lock_oe are 0 (status and lock floated).
- R2: hold_req passes through a two-stage synchroniser. When the bus is idle and hold_req is raised, hlda rises on the third rising clock edge. In that same cycle, bus_oe, ctl_oe, stat_oe and lock_oe all go to 0.
- R3: hlda falls on the third rising edge after hold_req goes low. After that, the bus stays released (bus_oe is 0) until a bus cycle is requested. The cycle is then accepted at once (cyc_go is 1), and all output enables return to 1 on the next edge.
- R4: A hold request that arrives during a bus cycle is not granted until cyc_done has closed that cycle. Status is therefore 111 at every grant.
- R5: During an accepted cycle, status shows the cycle type until cyc_done. The codes are: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write. Status is 111 when no cycle is running.
- R6: With enh_mode at 1, a refresh_pend that is 1 during a hold makes hlda fall on the next edge even though hold_req is still 1. The bus stays released until hold_req has been withdrawn, which takes three edges to take effect.
- R7: With enh_mode at 0, refresh_pend has no effect on a granted hold: hlda stays 1 while hold_req is 1.
- R8: lock_n goes to 0 at the start of a data cycle (type 001, 010, 101 or 110) that is accepted while lock_req is 1. It stays 0 until the first edge at which lock_req is 0. A fetch cycle accepted under lock_req does not assert it.
- R9: While lock_n is 0, a fetch request (type 100) is not accepted: cyc_go stays 0 and status stays 111.
- R10: While lock_n is 0, a hold request is not granted. The grant follows on the edge after lock_n returns to 1.
- R11: With enh_mode and refresh_pend both at 1, no new hold is granted, and a pending bus-cycle request is accepted instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | External master bus request, asynchronous, active high |
| cyc_req | input | 1 | CPU side wants to start a bus cycle |
| cyc_type | input | 3 | Status code of the requested cycle |
| cyc_done | input | 1 | Current bus cycle finishes at this edge |
| lock_req | input | 1 | A locked instruction is executing |
| refresh_pend | input | 1 | A memory refresh cycle is pending |
| enh_mode | input | 1 | Enhanced mode: reclaim the bus for refresh |
| hlda | output | 1 | Hold acknowledge |
| cyc_go | output | 1 | Requested cycle is accepted at this edge |
| bus_oe | output | 1 | Address/data output enable |
| ctl_oe | output | 1 | Control line output enable |
| stat_oe | output | 1 | Status output enable |
| status | output | 3 | Bus cycle status code |
| lock_oe | output | 1 | Lock output enable |
| lock_n | output | 1 | Active-low bus lock |

## Verification
A wrong ownership state shows up at once as a mismatch between hlda and the output enables. It can also appear as an acknowledge arriving one edge early or late against the fixed three-edge latency through the synchroniser. A corrupted lock state appears within one edge as a missing or stuck lock_n, a fetch that is accepted anyway, or a grant that breaks into a locked sequence. A wrong latched cycle type is visible on status for the whole length of the cycle. The enhanced-mode reclaim is checked by holding the request high and watching hlda fall on the very next edge.

// File: rtl/bus_hold_ctl.sv
module bus_hold_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_req,
  input  logic       cyc_req,
  input  logic [2:0] cyc_type,
  input  logic       cyc_done,
  input  logic       lock_req,
  input  logic       refresh_pend,
  input  logic       enh_mode,
  output logic       hlda,
  output logic       cyc_go,
  output logic       bus_oe,
  output logic       ctl_oe,
  output logic       stat_oe,
  output logic [2:0] status,
  output logic       lock_oe,
  output logic       lock_n
);
  localparam logic [2:0] ST_PASSIVE = 3'b111;
  localparam logic [2:0] ST_FETCH   = 3'b100;

  typedef enum logic [2:0] {OWN, BUSY, HELD, RECLAIM, FLOAT} own_t;

  own_t st;
  logic [SYNC_STAGES-1:0] sync_q;
  logic hold_s, lock_act, at_boundary, grant_go, data_cyc;
  logic [2:0] cur_type;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], hold_req};
  assign hold_s = sync_q[SYNC_STAGES-1];

  assign at_boundary = (st == OWN) || (st == FLOAT);
  assign grant_go = at_boundary && hold_s && !lock_act && !(enh_mode && refresh_pend);
  assign cyc_go = at_boundary && cyc_req && !grant_go && cyc_type != ST_PASSIVE
                  && !(lock_act && cyc_type == ST_FETCH);
  assign data_cyc = cyc_type inside {3'b001, 3'b010, 3'b101, 3'b110};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= OWN;
      cur_type <= ST_PASSIVE;
    end else begin
      unique case (st)
        OWN, FLOAT:
          if (grant_go) st <= HELD;
          else if (cyc_go) begin
            st <= BUSY;
            cur_type <= cyc_type;
          end
        BUSY:
          if (cyc_done) begin
            st <= OWN;
            cur_type <= ST_PASSIVE;
          end
        HELD:
          if (!hold_s) st <= FLOAT;
          else if (enh_mode && refresh_pend) st <= RECLAIM;
        RECLAIM:
          if (!hold_s) st <= FLOAT;
        default: st <= OWN;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_act <= 1'b0;
    else if (!lock_req) lock_act <= 1'b0;
    else if (cyc_go && data_cyc) lock_act <= 1'b1;

  assign hlda    = (st == HELD);
  assign bus_oe  = (st == OWN) || (st == BUSY);
  assign ctl_oe  = bus_oe;
  assign stat_oe = bus_oe && rst_n;
  assign lock_oe = bus_oe && rst_n;
  assign status  = (st == BUSY) ? cur_type : ST_PASSIVE;
  assign lock_n  = !lock_act;
endmodule

module bus_hold_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_s,
  input logic       cyc_type_fetch,
  input logic       lock_req,
  input logic       refresh_pend,
  input logic       enh_mode,
  input logic       hlda,
  input logic       cyc_go,
  input logic       bus_oe,
  input logic       ctl_oe,
  input logic       stat_oe,
  input logic       lock_oe,
  input logic [2:0] status,
  input logic       lock_n
);
  always_comb
    if (!rst_n) p_float_in_reset_r1: assert (!stat_oe && !lock_oe);

  p_release_with_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !bus_oe && !ctl_oe && !stat_oe && !lock_oe);

  p_grant_passive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(status == 3'b111));

  p_drop_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> $past(!hold_s || (enh_mode && refresh_pend)));

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && lock_req) |=> !lock_n);

  p_no_fetch_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && cyc_type_fetch) |-> !cyc_go);

  p_no_grant_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(lock_n));
endmodule

bind bus_hold_ctl bus_hold_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .cyc_type_fetch(cyc_type == 3'b100),
  .lock_req(lock_req), .refresh_pend(refresh_pend), .enh_mode(enh_mode),
  .hlda(hlda), .cyc_go(cyc_go), .bus_oe(bus_oe), .ctl_oe(ctl_oe),
  .stat_oe(stat_oe), .lock_oe(lock_oe), .status(status), .lock_n(lock_n)
);

// File: tb/tb_bus_hold_ctl.sv
module tb_bus_hold_ctl;
  logic clk = 0, rst_n = 0;
  logic hold_req = 0, cyc_req = 0, cyc_done = 0, lock_req = 0, refresh_pend = 0, enh_mode = 0;
  logic [2:0] cyc_type = 3'b111;
  logic hlda, cyc_go, bus_oe, ctl_oe, stat_oe, lock_oe, lock_n;
  logic [2:0] status;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  bus_hold_ctl dut (.*);

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(logic [2:0] t);
    cyc_req = 1; cyc_type = t;
    tick();
    cyc_req = 0;
    chk("R5", "status in cycle", status, t);
    chk("R5", "bus_oe in cycle", bus_oe, 1);
    cyc_done = 1;
    tick();
    cyc_done = 0;
    chk("R5", "status after cycle", status, 3'b111);
  endtask

  task automatic t_reset;
    chk("R1", "hlda", hlda, 0);
    chk("R1", "bus_oe", bus_oe, 1);
    chk("R1", "ctl_oe", ctl_oe, 1);
    chk("R1", "stat_oe", stat_oe, 0);
    chk("R1", "lock_oe", lock_oe, 0);
    chk("R1", "status", status, 3'b111);
    chk("R1", "lock_n", lock_n, 1);
    rst_n = 1;
    tick();
  endtask

  task automatic t_grant_release;
    hold_req = 1;
    tick(2);
    chk("R2", "hlda before sync", hlda, 0);
    tick();
    chk("R2", "hlda granted", hlda, 1);
    chk("R2", "oe released", {bus_oe, ctl_oe, stat_oe, lock_oe}, 0);
    hold_req = 0;
    tick(2);
    chk("R3", "hlda still high", hlda, 1);
    tick();
    chk("R3", "hlda dropped", hlda, 0);
    tick(2);
    chk("R3", "bus still floated", bus_oe, 0);
    cyc_req = 1; cyc_type = 3'b101;
    #1 chk("R3", "cyc_go from float", cyc_go, 1);
    tick();
    cyc_req = 0;
    chk("R3", "oe retaken", {bus_oe, ctl_oe, stat_oe, lock_oe}, 4'hF);
    cyc_done = 1; tick(); cyc_done = 0;
  endtask

  task automatic t_boundary;
    cyc_req = 1; cyc_type = 3'b110;
    tick();
    cyc_req = 0;
    hold_req = 1;
    tick(4);
    chk("R4", "no grant mid-cycle", hlda, 0);
    chk("R4", "status held", status, 3'b110);
    cyc_done = 1; tick(); cyc_done = 0;
    chk("R4", "no grant at done edge", hlda, 0);
    tick();
    chk("R4", "grant after boundary", hlda, 1);
    hold_req = 0;
    tick(3);
    chk("R4", "released", hlda, 0);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 7; c++) run_cycle(3'(c));
  endtask

  task automatic t_reclaim;
    enh_mode = 1; hold_req = 1;
    tick(3);
    chk("R6", "granted", hlda, 1);
    refresh_pend = 1;
    tick();
    chk("R6", "hlda dropped with hold high", hlda, 0);
    chk("R6", "bus floated", bus_oe, 0);
    tick(2);
    chk("R6", "still floated", bus_oe, 0);
    hold_req = 0;
    tick(3);
    chk("R6", "no regrant", hlda, 0);
    cyc_req = 1; cyc_type = 3'b101;
    tick();
    cyc_req = 0;
    chk("R6", "refresh cycle owns bus", bus_oe, 1);
    cyc_done = 1; tick(); cyc_done = 0;
    refresh_pend = 0; enh_mode = 0;
  endtask

  task automatic t_refresh_prio;
    enh_mode = 1; refresh_pend = 1; hold_req = 1;
    tick(4);
    chk("R11", "no grant while refresh", hlda, 0);
    cyc_req = 1; cyc_type = 3'b110;
    #1 chk("R11", "cycle accepted", cyc_go, 1);
    tick();
    cyc_req = 0;
    chk("R11", "status", status, 3'b110);
    cyc_done = 1; refresh_pend = 0; tick(); cyc_done = 0;
    tick();
    chk("R11", "grant after refresh", hlda, 1);
    hold_req = 0; enh_mode = 0;
    tick(3);
  endtask

  task automatic t_plain_mode;
    hold_req = 1;
    tick(3);
    chk("R7", "granted", hlda, 1);
    refresh_pend = 1;
    tick(3);
    chk("R7", "refresh ignored", hlda, 1);
    refresh_pend = 0; hold_req = 0;
    tick(3);
    chk("R7", "released", hlda, 0);
  endtask

  task automatic t_lock;
    lock_req = 1;
    run_cycle(3'b100);
    chk("R8", "fetch does not lock", lock_n, 1);
    cyc_req = 1; cyc_type = 3'b101;
    tick();
    cyc_req = 0;
    chk("R8", "locked at data cycle", lock_n, 0);
    cyc_done = 1; tick(); cyc_done = 0;
    chk("R8", "lock persists", lock_n, 0);
    cyc_req = 1; cyc_type = 3'b100;
    #1 chk("R9", "fetch refused", cyc_go, 0);
    tick();
    chk("R9", "status passive", status, 3'b111);
    cyc_req = 0;
    hold_req = 1;
    tick(4);
    chk("R10", "no grant under lock", hlda, 0);
    lock_req = 0;
    tick();
    chk("R8", "lock released", lock_n, 1);
    tick();
    chk("R10", "grant after unlock", hlda, 1);
    hold_req = 0;
    tick(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_grant_release();
    t_boundary();
    t_codes();
    t_reclaim();
    t_refresh_prio();
    t_plain_mode();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule